// File: doc/BRIEF.md
# Event Status Interrupt Aggregator

This block gathers single-cycle event pulses from up to 96 peripheral sources into three 32-bit sticky status words. Software acknowledges an event by writing a one to its status bit. Three independent groups of mask words sit over the same status words. Each group chooses which pending events drive its own level-sensitive interrupt line. Line A (group 0) is the highest-priority line, then line B (group 1), then line C (group 2).

Beside each line the block gives the number of the lowest pending event that the group has enabled, together with a valid flag. An interrupt handler can therefore go straight to the right source without scanning the status words. Software reaches all registers through a plain 32-bit word port. A write takes effect at the clock edge. Read data is combinational from the address.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A high level on `evt_i[n]` at a rising clock edge sets status bit `n mod 32` of status word `n / 32`. Status word k reads back at byte offset 4k (0x00, 0x04, 0x08) and shows its current value.
- R2: A write to a status word clears every bit that has a 1 in the write data. Bits written with 0 keep their value.
- R3: If an event is high in the same cycle that software writes a 1 to its status bit, the bit stays set.
- R4: Mask word k of group g sits at byte offset 0x10·(g+1) + 4k. It is read/write and reads back the last value written. A 1 bit enables the matching event for that group.
- R5: `irq_o[g]` is high exactly while some status bit is set whose mask bit in group g is also set. It stays high until all such bits are cleared or masked off. The groups act independently of one another.
- R6: `evt_idx_o[7g+6:7g]` gives the lowest event number (0..95) that is pending and enabled in group g. Event number 32k+j is bit j of status word k.
- R7: `idx_valid_o[g]` is high exactly when group g has a pending enabled event. When it is low, the index field reads 0.
- R8: Offsets that are not mapped read as zero, and writes to them change nothing. Unmapped offsets include every offset with nonzero low two bits, 0x0C, 0x1C, 0x2C, 0x3C and everything from 0x40 up.
- R9: While `rst_n` is low, all status and mask bits are zero, so every interrupt line and valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 96 | Event pulses, bit n = event n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 3 | Level interrupt per group, bit 0 = line A |
| evt_idx_o | output | 21 | Three 7-bit lowest-event indices, group g at bits 7g+6:7g |
| idx_valid_o | output | 3 | Index valid per group |

## Verification
The hardest case to reach from the ports is the collision between an acknowledge write and a fresh event on the same bit in the same cycle. The bench raises the event and the write strobe on the same falling edge, so both are seen at one rising edge. It then reads the word back. A second hard case is an event that is already pending but masked everywhere, which only becomes visible when a mask is enabled later. The bench captures an event with no mask set and checks that all lines stay low. It then enables a single mask bit and checks that the line rises and the index appears without any new pulse.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 3;
  localparam int N_GROUPS = 3;
  localparam int ADDR_W   = 8;
  // byte stride between mask groups; status words occupy the first stride
  localparam int GRP_STRIDE = 16;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 3,
  localparam int N_EVT  = WORD_W * N_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EVT-1:0]   evt_i,
  input  logic [N_WORDS-1:0] clr_sel_i,
  input  logic [WORD_W-1:0]  clr_data_i,
  output logic [N_EVT-1:0]   status_o
);
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] clr_bits;
    assign clr_bits = clr_sel_i[k] ? clr_data_i : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= (word_q & ~clr_bits) | evt_i[k*WORD_W +: WORD_W];
    end
    assign status_o[k*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int WORD_W   = 32,
  parameter int N_REGS   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REGS-1:0]        wr_sel_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [N_REGS*WORD_W-1:0] mask_o
);
  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    logic [WORD_W-1:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q <= '0;
      else if (wr_sel_i[r]) mask_q <= wdata_i;
    end
    assign mask_o[r*WORD_W +: WORD_W] = mask_q;
  end
endmodule

// File: rtl/evt_group_out.sv
module evt_group_out #(
  parameter int N_EVT = 96,
  localparam int IDX_W = $clog2(N_EVT)
) (
  input  logic [N_EVT-1:0] status_i,
  input  logic [N_EVT-1:0] mask_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  logic [N_EVT-1:0] pend;
  assign pend  = status_i & mask_i;
  assign irq_o = |pend;

  // scan from the top so the lowest set bit is the last one written
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx_o   = IDX_W'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evt_agg_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NW = N_WORDS,
  parameter int NG = N_GROUPS,
  parameter int AW = ADDR_W,
  localparam int N_EVT = W * NW,
  localparam int IDX_W = $clog2(N_EVT),
  localparam int N_MREG = NG * NW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVT-1:0]    evt_i,
  input  logic                reg_wr_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic [W-1:0]        reg_wdata_i,
  output logic [W-1:0]        reg_rdata_o,
  output logic [NG-1:0]       irq_o,
  output logic [NG*IDX_W-1:0] evt_idx_o,
  output logic [NG-1:0]       idx_valid_o
);
  logic [N_EVT-1:0]    status_w;
  logic [N_MREG*W-1:0] mask_w;
  logic [NW-1:0]       st_hit;
  logic [N_MREG-1:0]   mk_hit;

  // address decode: status word k at 4k, mask (g,k) at STRIDE*(g+1)+4k
  for (genvar k = 0; k < NW; k++) begin : g_st_dec
    assign st_hit[k] = (reg_addr_i == AW'(4 * k));
  end
  for (genvar g = 0; g < NG; g++) begin : g_grp_dec
    for (genvar k = 0; k < NW; k++) begin : g_word_dec
      assign mk_hit[g*NW + k] = (reg_addr_i == AW'(GRP_STRIDE * (g + 1) + 4 * k));
    end
  end

  evt_status_bank #(.WORD_W(W), .N_WORDS(NW)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .clr_sel_i  (st_hit & {NW{reg_wr_i}}),
    .clr_data_i (reg_wdata_i),
    .status_o   (status_w)
  );

  evt_mask_bank #(.WORD_W(W), .N_REGS(N_MREG)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel_i (mk_hit & {N_MREG{reg_wr_i}}),
    .wdata_i  (reg_wdata_i),
    .mask_o   (mask_w)
  );

  for (genvar g = 0; g < NG; g++) begin : g_out
    evt_group_out #(.N_EVT(N_EVT)) u_grp (
      .status_i (status_w),
      .mask_i   (mask_w[g*N_EVT +: N_EVT]),
      .irq_o    (irq_o[g]),
      .idx_o    (evt_idx_o[g*IDX_W +: IDX_W]),
      .valid_o  (idx_valid_o[g])
    );
  end

  // read mux: at most one decode hit, unmapped yields zero
  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NW; k++)
      if (st_hit[k]) reg_rdata_o = status_w[k*W +: W];
    for (int r = 0; r < N_MREG; r++)
      if (mk_hit[r]) reg_rdata_o = mask_w[r*W +: W];
  end
endmodule

// File: rtl/evt_irq_aggregator_chk.sv
module evt_irq_aggregator_chk #(
  parameter int W  = 32,
  parameter int NW = 3,
  parameter int NG = 3,
  parameter int AW = 8,
  localparam int N_EVT = W * NW,
  localparam int IDX_W = $clog2(N_EVT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_EVT-1:0]    evt_i,
  input logic                reg_wr_i,
  input logic [AW-1:0]       reg_addr_i,
  input logic [W-1:0]        reg_wdata_i,
  input logic [NG-1:0]       irq_o,
  input logic [NG*IDX_W-1:0] evt_idx_o,
  input logic [NG-1:0]       idx_valid_o,
  input logic [N_EVT-1:0]    status_w,
  input logic [NG*N_EVT-1:0] mask_w
);
  // R1: a pulse is captured on the next edge
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_w & $past(evt_i)) == $past(evt_i)));

  // R1/R2: status only moves when an event or a write arrives
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && evt_i == '0) |=> $stable(status_w));

  // R9: no pending bits means no interrupt
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w == '0) |-> (irq_o == '0 && idx_valid_o == '0));

  for (genvar k = 0; k < NW; k++) begin : g_w1c
    // R2/R3: written ones vanish unless the same edge re-raised them
    a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == AW'(4 * k)) |=>
      ((status_w[k*W +: W] & $past(reg_wdata_i) & ~$past(evt_i[k*W +: W])) == '0));
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [N_EVT-1:0] pend;
    logic [IDX_W-1:0] idx;
    assign pend = status_w & mask_w[g*N_EVT +: N_EVT];
    assign idx  = evt_idx_o[g*IDX_W +: IDX_W];
    // R6: reported event is pending and nothing below it is
    a_r6_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid_o[g] |-> (pend[idx] && (pend & ~({N_EVT{1'b1}} << idx)) == '0));
    // R7: flag tracks the line, index rests at zero
    a_r7_valid_line: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid_o[g] == irq_o[g]) && (idx_valid_o[g] || idx == '0));
  end
endmodule

bind evt_irq_aggregator evt_irq_aggregator_chk #(
  .W(W), .NW(NW), .NG(NG), .AW(AW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .evt_idx_o   (evt_idx_o),
  .idx_valid_o (idx_valid_o),
  .status_w    (status_w),
  .mask_w      (mask_w)
);

// File: tb/evt_irq_aggregator_tb_top.sv
module evt_irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  logic [20:0] idx;
  logic [2:0]  vld;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .evt_idx_o(idx),
    .idx_valid_o(vld)
  );

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wval;
    logic [7:0]  raddr;
    logic [31:0] rexp;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{8'h14, 32'h1234_5678, 8'h14, 32'h1234_5678},  // R4
    '{8'h28, 32'hFFFF_0000, 8'h28, 32'hFFFF_0000},  // R4
    '{8'h30, 32'h0000_0001, 8'h30, 32'h0000_0001},  // R4
    '{8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000},  // R8
    '{8'h1C, 32'hFFFF_FFFF, 8'h1C, 32'h0000_0000},  // R8
    '{8'h15, 32'h0000_FFFF, 8'h14, 32'h1234_5678},  // R8 misaligned
    '{8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000},  // R8
    '{8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input logic [95:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic outs(input string req, input logic [2:0] ei, input logic [2:0] ev,
                      input logic [6:0] i0, input logic [6:0] i1, input logic [6:0] i2);
    check({req, " irq"}, 32'(irq), 32'(ei));
    check({req, " valid"}, 32'(vld), 32'(ev));
    check({req, " idx0"}, 32'(idx[6:0]), 32'(i0));
    check({req, " idx1"}, 32'(idx[13:7]), 32'(i1));
    check({req, " idx2"}, 32'(idx[20:14]), 32'(i2));
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    outs("R9 reset", 3'b000, 3'b000, 7'd0, 7'd0, 7'd0);
    reg_read("R9 status0", 8'h00, 32'h0);
    reg_read("R9 mask", 8'h20, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      reg_write(TBL[i].waddr, TBL[i].wval);
      reg_read($sformatf("R4/R8 vec%0d", i), TBL[i].raddr, TBL[i].rexp);
    end
    reg_write(8'h28, 32'h0);
    reg_write(8'h30, 32'h0);

    // masks: g0 w0 bit4; g1 w1 all; g2 w2 bit31 and w0 bit4
    reg_write(8'h10, 32'h0000_0010);
    reg_write(8'h24, 32'hFFFF_FFFF);
    reg_write(8'h38, 32'h8000_0000);
    reg_write(8'h30, 32'h0000_0010);
    outs("R5 masked idle", 3'b000, 3'b000, 7'd0, 7'd0, 7'd0);

    pulse((96'd1 << 4) | (96'd1 << 40) | (96'd1 << 95));
    reg_read("R1 word0", 8'h00, 32'h0000_0010);
    reg_read("R1 word1", 8'h04, 32'h0000_0100);
    reg_read("R1 word2", 8'h08, 32'h8000_0000);
    outs("R6 three groups", 3'b111, 3'b111, 7'd4, 7'd40, 7'd4);

    reg_write(8'h00, 32'h0);
    reg_read("R2 zero write", 8'h00, 32'h0000_0010);
    outs("R5 level held", 3'b111, 3'b111, 7'd4, 7'd40, 7'd4);

    reg_write(8'h00, 32'hFFFF_FFEF);
    reg_read("R2 other ones", 8'h00, 32'h0000_0010);
    reg_write(8'h00, 32'h0000_0010);
    reg_read("R2 ack", 8'h00, 32'h0);
    outs("R6 next lowest", 3'b110, 3'b110, 7'd0, 7'd40, 7'd95);

    // R3 set and clear in the same cycle
    @(negedge clk); evt = 96'd1 << 40; wr = 1'b1; addr = 8'h04; wdata = 32'h0000_0100;
    @(negedge clk); evt = '0; wr = 1'b0;
    reg_read("R3 set wins", 8'h04, 32'h0000_0100);

    reg_write(8'h04, 32'hFFFF_FFFF);
    reg_write(8'h08, 32'h8000_0000);
    outs("R7 all clear", 3'b000, 3'b000, 7'd0, 7'd0, 7'd0);

    // pending but not enabled anywhere, then enabled later
    pulse(96'd1 << 70);
    reg_read("R1 word2 bit6", 8'h08, 32'h0000_0040);
    outs("R5 unmasked pending", 3'b000, 3'b000, 7'd0, 7'd0, 7'd0);
    reg_write(8'h28, 32'h0000_0040);
    outs("R5 late enable", 3'b010, 3'b010, 7'd0, 7'd70, 7'd0);
    reg_write(8'h28, 32'h0);
    outs("R5 masked off", 3'b000, 3'b000, 7'd0, 7'd0, 7'd0);

    // R8 unmapped writes leave masks and status alone
    reg_write(8'h3C, 32'hFFFF_FFFF);
    reg_write(8'h09, 32'hFFFF_FFFF);
    reg_read("R8 status kept", 8'h08, 32'h0000_0040);
    reg_read("R8 mask kept", 8'h38, 32'h8000_0000);
    reg_read("R8 read 3C", 8'h3C, 32'h0);

    // R9 reset mid-run
    pulse(96'd1 << 4);
    outs("R9 pre", 3'b101, 3'b101, 7'd4, 7'd0, 7'd4);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    outs("R9 midrun", 3'b000, 3'b000, 7'd0, 7'd0, 7'd0);
    reg_read("R9 status cleared", 8'h00, 32'h0);
    reg_read("R9 mask cleared", 8'h10, 32'h0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule